// File: doc/BRIEF.md
# Programmable Swap Indicator Selector

This block drives one general-purpose status bit of a video output port. A static mode select picks what the bit carries. It can carry a marker for the first frame shown after the frame buffers have been exchanged. It can instead carry one of the raster event strobes that the timing generator supplies. It can also be tied to a fixed level. The output is registered on the pixel clock, so it has no glitches and a fixed delay of one cycle.

In the default mode, a swap request pulse arms an internal flag. The next fetch window that opens after the pulse carries the indication for its whole duration. The output in that mode is the fetch-window enable gated by the flag. The flag is cleared when that window closes, so the indication covers exactly one frame. The raster timing generator and the buffer-exchange mechanism sit outside this block.

Top module: `swapind_sel`

## Requirements
- R1: While `rst_n` is low, `ind_out` goes low at the next clock edge, and any armed swap state is discarded. A swap seen before reset gives no indication after it.
- R2: `ind_out` at clock edge k+1 equals the source selected at edge k. Codes: 1 = line start, 2 = field start, 3 = frame start, 4 = tri-level sync, 5 = fetch-window enable. The strobes that are not selected have no effect.
- R3: Code 6 drives `ind_out` high and code 7 drives it low, whatever the strobes and the swap input do.
- R4: Under code 0, `ind_out` is high only when `fetch_win` was high at the previous edge.
- R5: Under code 0, a `swap_pulse` seen in a cycle arms the indication. The first fetch window whose opening cycle (first cycle with `fetch_win` high after a low cycle) comes later than the pulse then drives `ind_out` high for every cycle of that window.
- R6: Under code 0, the indication stops when that window closes. Later windows leave `ind_out` low unless a new swap pulse arrives.
- R7: Under code 0, a swap pulse that falls inside a window, or on its opening cycle, does not mark that window. It marks the next one.
- R8: Under code 0, several swap pulses before one window produce an indication in that one window only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 3 | Static source select (codes in R2, R3; 0 = swap-gated) |
| ev_line | input | 1 | Line start strobe |
| ev_field | input | 1 | Field start strobe |
| ev_frame | input | 1 | Frame start strobe |
| ev_trisync | input | 1 | Tri-level sync strobe |
| fetch_win | input | 1 | Frame-buffer fetch window enable |
| swap_pulse | input | 1 | Buffer swap completed, one-cycle pulse |
| ind_out | output | 1 | Registered indicator output |

## Verification
The strobe modes are each driven with their own strobe alone and then with every other strobe and the swap input active. This separates correct selection from leakage of a neighbouring source, and the constant codes get the same two patterns. The swap-gated mode is run over a sequence of short frames. Swaps are placed in blanking, in mid-window, on the opening cycle of a window and twice before one window, so that a flag that releases too early, clears too late, or counts pulses shows up as a wrong frame being marked. A swap followed by a reset shows whether reset discards the armed state.

// File: rtl/swapind_pkg.sv
// Package: shared select codes and widths for the swap indicator selector.
// Assumes the select field is static while the port runs.
package swapind_pkg;
    localparam int SEL_W = 3;
    localparam int N_EV  = 5;

    typedef enum logic [SEL_W-1:0] {
        SRC_SWAP   = 3'd0,
        SRC_LINE   = 3'd1,
        SRC_FIELD  = 3'd2,
        SRC_FRAME  = 3'd3,
        SRC_TRISYN = 3'd4,
        SRC_FETCH  = 3'd5,
        SRC_HIGH   = 3'd6,
        SRC_LOW    = 3'd7
    } src_sel_e;

    // Event bundle bit positions; the mux indexes them as code - 1.
    localparam int EV_LINE   = 0;
    localparam int EV_FIELD  = 1;
    localparam int EV_FRAME  = 2;
    localparam int EV_TRISYN = 3;
    localparam int EV_FETCH  = 4;
endpackage

// File: rtl/swapind_flag.sv
// Module: swapind_flag
// Tracks buffer swaps and produces the fetch window gated by a latched
// swap flag. A swap arms "pending". The next window opening moves it to
// "active". Active drops when the window closes.
// Assumes swap_pulse is a single-cycle strobe in the pixel clock domain.
module swapind_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_win,
    input  logic swap_pulse,
    output logic gate_o
);
    logic fe_d;
    logic pending_q;
    logic active_q;
    logic win_start;

    // Opening cycle of a fetch window.
    assign win_start = fetch_win & ~fe_d;

    // Fetch-window history, swap arming and one-window release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_d      <= 1'b0;
            pending_q <= 1'b0;
            active_q  <= 1'b0;
        end else begin
            fe_d      <= fetch_win;
            pending_q <= swap_pulse | (pending_q & ~win_start);
            if (win_start)
                active_q <= pending_q;
            else
                active_q <= fetch_win & active_q;
        end
    end

    // Window qualified by the flag; the opening cycle uses pending directly.
    always_comb begin
        gate_o = fetch_win & (win_start ? pending_q : active_q);
    end

    // A swap always leaves the flag armed on the next cycle.
    p_swap_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |=> pending_q);

    // Active never survives a closed window.
    p_window_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_win |=> !active_q);

    // A window opened without an armed swap is never marked.
    p_unarmed_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_win && !fe_d && !pending_q) |=> !active_q);
endmodule

// File: rtl/swapind_mux.sv
// Module: swapind_mux
// Picks the next indicator value from the mode select.
// Assumes ev_i is packed according to the EV_* positions in swapind_pkg.
module swapind_mux
    import swapind_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_EV-1:0]  ev_i,
    input  logic             gate_i,
    output logic             nxt_o
);
    // Static source selection.
    always_comb begin
        case (src_sel_e'(sel_i))
            SRC_SWAP:   nxt_o = gate_i;
            SRC_LINE:   nxt_o = ev_i[EV_LINE];
            SRC_FIELD:  nxt_o = ev_i[EV_FIELD];
            SRC_FRAME:  nxt_o = ev_i[EV_FRAME];
            SRC_TRISYN: nxt_o = ev_i[EV_TRISYN];
            SRC_FETCH:  nxt_o = ev_i[EV_FETCH];
            SRC_HIGH:   nxt_o = 1'b1;
            default:    nxt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/swapind_sel.sv
// Module: swapind_sel (top)
// Multipurpose status bit for a video port: the swap-gated fetch window,
// a raster strobe or a constant, chosen by mode_sel and registered once.
// Assumes mode_sel only changes while the port is idle or in reset.
module swapind_sel
    import swapind_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] mode_sel,
    input  logic             ev_line,
    input  logic             ev_field,
    input  logic             ev_frame,
    input  logic             ev_trisync,
    input  logic             fetch_win,
    input  logic             swap_pulse,
    output logic             ind_out
);
    logic [N_EV-1:0] ev_bus;
    logic            gate;
    logic            nxt;

    // Pack strobes in package order.
    always_comb begin
        ev_bus            = '0;
        ev_bus[EV_LINE]   = ev_line;
        ev_bus[EV_FIELD]  = ev_field;
        ev_bus[EV_FRAME]  = ev_frame;
        ev_bus[EV_TRISYN] = ev_trisync;
        ev_bus[EV_FETCH]  = fetch_win;
    end

    swapind_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_win  (fetch_win),
        .swap_pulse (swap_pulse),
        .gate_o     (gate)
    );

    swapind_mux u_mux (
        .sel_i  (mode_sel),
        .ev_i   (ev_bus),
        .gate_i (gate),
        .nxt_o  (nxt)
    );

    // Glitch-free output register.
    always_ff @(posedge clk) begin
        if (!rst_n) ind_out <= 1'b0;
        else        ind_out <= nxt;
    end

    p_reset_low_r1: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> !ind_out);

    p_line_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd1) |=> (ind_out == $past(ev_line)));

    p_tri_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd4) |=> (ind_out == $past(ev_trisync)));

    p_const_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd6) |=> ind_out);

    p_const_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd7) |=> !ind_out);

    p_gated_by_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0 && !fetch_win) |=> !ind_out);
endmodule

// File: tb/swapind_sel_tb_top.sv
`timescale 1ns/1ps
module swapind_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic       ev_line, ev_field, ev_frame, ev_trisync, fetch_win, swap_pulse;
    logic       ind_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    swapind_sel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .ev_line    (ev_line),
        .ev_field   (ev_field),
        .ev_frame   (ev_frame),
        .ev_trisync (ev_trisync),
        .fetch_win  (fetch_win),
        .swap_pulse (swap_pulse),
        .ind_out    (ind_out)
    );

    // Vector: {sel[2:0], line, field, frame, tri, fetch, swap, expected}
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {3'd1, 5'b10000, 1'b0, 1'b1},
        {3'd1, 5'b01111, 1'b1, 1'b0},
        {3'd2, 5'b01000, 1'b0, 1'b1},
        {3'd2, 5'b10111, 1'b1, 1'b0},
        {3'd3, 5'b00100, 1'b0, 1'b1},
        {3'd3, 5'b11011, 1'b1, 1'b0},
        {3'd4, 5'b00010, 1'b0, 1'b1},
        {3'd4, 5'b11101, 1'b1, 1'b0},
        {3'd5, 5'b00001, 1'b0, 1'b1},
        {3'd5, 5'b11110, 1'b1, 1'b0},
        {3'd6, 5'b00000, 1'b0, 1'b1},
        {3'd6, 5'b11111, 1'b1, 1'b1},
        {3'd7, 5'b11111, 1'b1, 1'b0},
        {3'd7, 5'b00000, 1'b0, 1'b0}
    };

    task automatic chk(input logic exp, input string tag);
        total++;
        if (ind_out !== exp) begin
            bad++;
            $display("FAIL %s: ind_out=%b expected=%b at %0t", tag, ind_out, exp, $time);
        end
    endtask

    // Drive at negedge, let one edge pass, check at the following negedge.
    task automatic step(input logic fe, input logic sw, input logic exp, input string tag);
        fetch_win  = fe;
        swap_pulse = sw;
        @(posedge clk);
        @(negedge clk);
        chk(exp, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fetch_win = 1'b0; swap_pulse = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mode_sel = 3'd6;
        {ev_line, ev_field, ev_frame, ev_trisync, fetch_win, swap_pulse} = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R1 output low in reset with constant-high code");
        rst_n = 1'b1;

        // Table walk over strobe and constant modes (R2, R3).
        for (int i = 0; i < NV; i++) begin
            mode_sel = VEC[i][9:7];
            {ev_line, ev_field, ev_frame, ev_trisync, fetch_win} = VEC[i][6:2];
            swap_pulse = VEC[i][1];
            @(posedge clk);
            @(negedge clk);
            chk(VEC[i][0], (VEC[i][9:7] >= 3'd6) ? "R3 constant code" : "R2 strobe select");
        end
        {ev_line, ev_field, ev_frame, ev_trisync} = '0;

        // Swap-gated mode.
        mode_sel = 3'd0;
        do_reset();
        // Window without swap: R4, R6.
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, "R6 no swap no mark");
        step(1'b0, 1'b0, 1'b0, "R4 blank low");
        // Swap in blanking, next window fully marked: R5.
        step(1'b0, 1'b1, 1'b0, "R4 swap in blanking");
        step(1'b0, 1'b0, 1'b0, "R4 blank low after swap");
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1, "R5 first window after swap");
        step(1'b0, 1'b0, 1'b0, "R4 low after window");
        step(1'b0, 1'b0, 1'b0, "R4 low after window");
        // Following window unmarked: R6.
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, "R6 later window unmarked");
        step(1'b0, 1'b0, 1'b0, "R6 blank");
        // Swap mid-window: R7.
        step(1'b1, 1'b0, 1'b0, "R7 window open");
        step(1'b1, 1'b1, 1'b0, "R7 swap mid-window");
        step(1'b1, 1'b0, 1'b0, "R7 current window unmarked");
        step(1'b0, 1'b0, 1'b0, "R7 blank");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b1, "R7 next window marked");
        step(1'b0, 1'b0, 1'b0, "R6 blank");
        // Swap on opening cycle: R7.
        step(1'b1, 1'b1, 1'b0, "R7 swap on opening cycle");
        step(1'b1, 1'b0, 1'b0, "R7 opening-cycle window unmarked");
        step(1'b0, 1'b0, 1'b0, "R7 blank");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b1, "R7 window after opening-cycle swap");
        step(1'b0, 1'b0, 1'b0, "R6 blank");
        // Two swaps before one window: R8.
        step(1'b0, 1'b1, 1'b0, "R8 first swap");
        step(1'b0, 1'b1, 1'b0, "R8 second swap");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b1, "R8 one window marked");
        step(1'b0, 1'b0, 1'b0, "R8 blank");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b0, "R8 only one window");
        step(1'b0, 1'b0, 1'b0, "R8 blank");
        // Swap then reset discards the armed state: R1.
        step(1'b0, 1'b1, 1'b0, "R1 swap before reset");
        do_reset();
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b0, "R1 armed swap discarded by reset");
        step(1'b0, 1'b0, 1'b0, "R1 blank");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule